// File: doc/BRIEF.md
# Performance monitor control register file

This block is the system-register slave for a performance monitor that has no event counters. A requester presents one access per cycle. Each access carries a select made of a primary number, a secondary number, an opcode1 field and a 3-bit opcode, plus a write flag, 32-bit write data and a flag saying whether the requester runs at the privileged level. The block answers in the same cycle with read data and an undefined-access flag. An accepted write takes effect at the next rising clock edge.

The stored state is small: a control word with a few writable bits, two single-bit enables that each have a set view and a clear view, an overflow status word cleared by writing ones, an 8-bit event type and a one-bit user-enable. The user-enable decides which accesses are allowed at the unprivileged level. The locations for the cycle counter, the event counter, software increment and counter select are present in the map, but they read as zero and ignore writes.

Top module: `pmu_sysreg_file`

## Requirements
- R1: Synchronous reset, active high. After reset, control bits 31:24 equal bits 31:24 of `id_main` and every other stored bit is zero.
- R2: Writing control (secondary 12, opcode 0) changes only bits 0, 3, 4 and 5 (mask 0x39). All other control bits keep their value.
- R3: Count-enable set (secondary 12, opcode 1) and count-enable clear (secondary 12, opcode 2) both read one stored bit, which appears at bit 31. A write to set with data bit 31 high sets it. A write to clear with data bit 31 high clears it. Data bits 30:0 have no effect.
- R4: Interrupt-enable set (secondary 14, opcode 1) and interrupt-enable clear (secondary 14, opcode 2) work the same way as R3 on their own stored bit, which appears at bit 31.
- R5: A write to overflow status (secondary 12, opcode 3) clears each stored bit whose data bit is 1. Nothing sets these bits, so the location reads zero.
- R6: Event type (secondary 13, opcode 1) stores data bits 7:0 and reads with bits 31:8 zero.
- R7: User-enable (secondary 14, opcode 0) stores data bit 0 and reads it at bit 0.
- R8: Software increment (12/4), counter select (12/5), cycle count (13/0) and event count (13/2) read as zero and ignore writes.
- R9: At the unprivileged level, every access to interrupt-enable set or clear is refused.
- R10: At the unprivileged level, reads of user-enable are allowed and writes to it are refused. The privileged level may read and write it.
- R11: At the unprivileged level, every other mapped register is refused while user-enable is 0 and allowed while it is 1.
- R12: An access is unmapped when the primary number is not 9, opcode1 is non-zero, or the secondary/opcode pair is not listed in R2 to R8. An unmapped access is refused. A refused access changes no stored state.
- R13: `undef` is high only for a refused request. `rdata` is zero unless an accepted read is presented, and zero when `undef` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_main | input | 32 | Main ID word; bits 31:24 seed control at reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged level, 0 = unprivileged |
| sel_primary | input | 4 | Primary register number |
| sel_secondary | input | 4 | Secondary register number |
| sel_op1 | input | 3 | Opcode1 field, must be zero |
| sel_op2 | input | 3 | Opcode selecting within a secondary |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, same cycle |
| undef | output | 1 | Access refused, same cycle |

## Verification
Stored state is only visible through reads, so a corrupted bit in control, an enable, event type or user-enable shows up on the next privileged read of that location. This read comes one cycle after the faulty write. A wrong user-enable is different: it appears at once as a changed `undef` answer on every gated unprivileged access. The bench therefore sweeps every secondary/opcode pair, both levels, both values of user-enable, and mapped and unmapped primary/opcode1 values. Each access is compared with a model built from the requirements, so both a bad decision and a bad stored value are caught on the next access.

// File: rtl/pmu_regs_pkg.sv
package pmu_regs_pkg;

    localparam int unsigned PMU_DW     = 32;
    localparam int unsigned PMU_SELW   = 4;
    localparam int unsigned PMU_OPW    = 3;
    localparam int unsigned PMU_EVT_W  = 8;
    localparam int unsigned PMU_ID_LSB = 24;
    localparam int unsigned PMU_ENA_BIT = 31;

    localparam logic [PMU_SELW-1:0] PMU_PRIMARY = 4'd9;
    localparam logic [PMU_SELW-1:0] SEC_CTL     = 4'd12;
    localparam logic [PMU_SELW-1:0] SEC_CNT     = 4'd13;
    localparam logic [PMU_SELW-1:0] SEC_USR     = 4'd14;

    localparam logic [PMU_DW-1:0] CTRL_WMASK = 32'h0000_0039;
    localparam logic [PMU_DW-1:0] ID_MASK    = ~((32'h1 << PMU_ID_LSB) - 32'h1);

    typedef enum logic [3:0] {
        RG_CTRL,
        RG_CNTEN_SET,
        RG_CNTEN_CLR,
        RG_OVF,
        RG_SWINC,
        RG_CSEL,
        RG_CYC,
        RG_EVTYPE,
        RG_EVCNT,
        RG_USREN,
        RG_INTEN_SET,
        RG_INTEN_CLR,
        RG_NONE
    } pmu_reg_e;

    typedef enum logic [1:0] {
        AC_GATED,
        AC_USER_RO,
        AC_PRIV_ONLY
    } pmu_acc_e;

    typedef struct packed {
        logic [PMU_DW-1:0]    ctrl;
        logic                 cnt_en;
        logic                 int_en;
        logic [PMU_DW-1:0]    ovf;
        logic [PMU_EVT_W-1:0] evtype;
        logic                 usr_en;
    } pmu_state_t;

    function automatic pmu_reg_e pmu_lookup(
        input logic [PMU_SELW-1:0] prim,
        input logic [PMU_SELW-1:0] sec,
        input logic [PMU_OPW-1:0]  op1,
        input logic [PMU_OPW-1:0]  op2
    );
        pmu_reg_e r;
        r = RG_NONE;
        if (prim == PMU_PRIMARY && op1 == '0) begin
            if (sec == SEC_CTL) begin
                case (op2)
                    3'd0: r = RG_CTRL;
                    3'd1: r = RG_CNTEN_SET;
                    3'd2: r = RG_CNTEN_CLR;
                    3'd3: r = RG_OVF;
                    3'd4: r = RG_SWINC;
                    3'd5: r = RG_CSEL;
                    default: r = RG_NONE;
                endcase
            end else if (sec == SEC_CNT) begin
                case (op2)
                    3'd0: r = RG_CYC;
                    3'd1: r = RG_EVTYPE;
                    3'd2: r = RG_EVCNT;
                    default: r = RG_NONE;
                endcase
            end else if (sec == SEC_USR) begin
                case (op2)
                    3'd0: r = RG_USREN;
                    3'd1: r = RG_INTEN_SET;
                    3'd2: r = RG_INTEN_CLR;
                    default: r = RG_NONE;
                endcase
            end
        end
        return r;
    endfunction

    function automatic pmu_acc_e pmu_class(input pmu_reg_e r);
        case (r)
            RG_INTEN_SET, RG_INTEN_CLR: return AC_PRIV_ONLY;
            RG_USREN:                   return AC_USER_RO;
            default:                    return AC_GATED;
        endcase
    endfunction

    function automatic logic pmu_permit(
        input pmu_reg_e r,
        input logic     write,
        input logic     priv,
        input logic     usr_en
    );
        logic ok;
        case (pmu_class(r))
            AC_PRIV_ONLY: ok = priv;
            AC_USER_RO:   ok = priv | ~write;
            default:      ok = priv | usr_en;
        endcase
        return ok & (r != RG_NONE);
    endfunction

endpackage

// File: rtl/pmu_access_check.sv
module pmu_access_check
    import pmu_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_priv,
    input  logic [PMU_SELW-1:0] sel_primary,
    input  logic [PMU_SELW-1:0] sel_secondary,
    input  logic [PMU_OPW-1:0]  sel_op1,
    input  logic [PMU_OPW-1:0]  sel_op2,
    input  logic                usr_en,
    output pmu_reg_e            reg_id,
    output logic                refused,
    output logic                accept_wr,
    output logic                accept_rd
);

    logic permit;

    always_comb begin
        reg_id    = pmu_lookup(sel_primary, sel_secondary, sel_op1, sel_op2);
        permit    = pmu_permit(reg_id, req_write, req_priv, usr_en);
        refused   = req_valid & ~permit;
        accept_wr = req_valid & permit & req_write;
        accept_rd = req_valid & permit & ~req_write;
    end

    // R9: interrupt-enable views are closed to the unprivileged level
    a_r9_inten_priv_only: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && sel_primary == PMU_PRIMARY && sel_op1 == '0 &&
         sel_secondary == SEC_USR && (sel_op2 == 3'd1 || sel_op2 == 3'd2)) |-> refused);

    // R10: unprivileged write to user-enable is refused
    a_r10_usren_user_wr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_priv && reg_id == RG_USREN) |-> refused);

    // R12: unmapped selects never reach the store
    a_r12_unmapped: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sel_primary != PMU_PRIMARY) |-> (refused && !accept_wr && !accept_rd));

endmodule

// File: rtl/pmu_setclr_bit.sv
module pmu_setclr_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_we,
    input  logic clr_we,
    input  logic din,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (set_we && din)
            q <= 1'b1;
        else if (clr_we && din)
            q <= 1'b0;
    end

    // R3 / R4: a set view write with bit high leaves the bit set
    a_r3_set_takes: assert property (@(posedge clk) disable iff (rst)
        (set_we && din) |=> q);

    // R3 / R4: a clear view write with bit high leaves the bit clear
    a_r4_clr_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we && din) |=> !q);

endmodule

// File: rtl/pmu_state_regs.sv
module pmu_state_regs
    import pmu_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PMU_DW-1:0] id_main,
    input  pmu_reg_e          reg_id,
    input  logic              accept_wr,
    input  logic [PMU_DW-1:0] wdata,
    output pmu_state_t        st
);

    localparam int unsigned N_PAIR = 2;

    logic [N_PAIR-1:0] set_we;
    logic [N_PAIR-1:0] clr_we;
    logic [N_PAIR-1:0] pair_q;

    always_comb begin
        set_we[0] = accept_wr & (reg_id == RG_CNTEN_SET);
        clr_we[0] = accept_wr & (reg_id == RG_CNTEN_CLR);
        set_we[1] = accept_wr & (reg_id == RG_INTEN_SET);
        clr_we[1] = accept_wr & (reg_id == RG_INTEN_CLR);
    end

    genvar g;
    generate
        for (g = 0; g < N_PAIR; g++) begin : g_pair
            pmu_setclr_bit u_bit (
                .clk    (clk),
                .rst    (rst),
                .set_we (set_we[g]),
                .clr_we (clr_we[g]),
                .din    (wdata[PMU_ENA_BIT]),
                .q      (pair_q[g])
            );
        end
    endgenerate

    assign st.cnt_en = pair_q[0];
    assign st.int_en = pair_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st.ctrl   <= id_main & ID_MASK;
            st.ovf    <= '0;
            st.evtype <= '0;
            st.usr_en <= 1'b0;
        end else if (accept_wr) begin
            case (reg_id)
                RG_CTRL:   st.ctrl   <= (st.ctrl & ~CTRL_WMASK) | (wdata & CTRL_WMASK);
                RG_OVF:    st.ovf    <= st.ovf & ~wdata;
                RG_EVTYPE: st.evtype <= wdata[PMU_EVT_W-1:0];
                RG_USREN:  st.usr_en <= wdata[0];
                default: ;
            endcase
        end
    end

    // R2: bits outside the writable mask never move after reset
    a_r2_ctrl_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st.ctrl & ~CTRL_WMASK) == ($past(st.ctrl) & ~CTRL_WMASK)));

    // R5: bits written as one are clear afterwards
    a_r5_ovf_w1c: assert property (@(posedge clk) disable iff (rst)
        (accept_wr && reg_id == RG_OVF) |=> ((st.ovf & $past(wdata)) == '0));

    // R7: user-enable follows data bit 0 of an accepted write
    a_r7_usren_bit0: assert property (@(posedge clk) disable iff (rst)
        (accept_wr && reg_id == RG_USREN) |=> (st.usr_en == $past(wdata[0])));

endmodule

// File: rtl/pmu_read_mux.sv
module pmu_read_mux
    import pmu_regs_pkg::*;
(
    input  pmu_reg_e          reg_id,
    input  pmu_state_t        st,
    output logic [PMU_DW-1:0] value
);

    always_comb begin
        value = '0;
        case (reg_id)
            RG_CTRL:                    value = st.ctrl;
            RG_CNTEN_SET, RG_CNTEN_CLR: value[PMU_ENA_BIT] = st.cnt_en;
            RG_OVF:                     value = st.ovf;
            RG_EVTYPE:                  value[PMU_EVT_W-1:0] = st.evtype;
            RG_USREN:                   value[0] = st.usr_en;
            RG_INTEN_SET, RG_INTEN_CLR: value[PMU_ENA_BIT] = st.int_en;
            default:                    value = '0;
        endcase
    end

endmodule

// File: rtl/pmu_sysreg_file.sv
module pmu_sysreg_file
    import pmu_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] id_main,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_priv,
    input  logic [3:0]  sel_primary,
    input  logic [3:0]  sel_secondary,
    input  logic [2:0]  sel_op1,
    input  logic [2:0]  sel_op2,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        undef
);

    pmu_reg_e          reg_id;
    pmu_state_t        st;
    logic              refused;
    logic              accept_wr;
    logic              accept_rd;
    logic [PMU_DW-1:0] rd_value;

    pmu_access_check u_check (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_priv      (req_priv),
        .sel_primary   (sel_primary),
        .sel_secondary (sel_secondary),
        .sel_op1       (sel_op1),
        .sel_op2       (sel_op2),
        .usr_en        (st.usr_en),
        .reg_id        (reg_id),
        .refused       (refused),
        .accept_wr     (accept_wr),
        .accept_rd     (accept_rd)
    );

    pmu_state_regs u_state (
        .clk       (clk),
        .rst       (rst),
        .id_main   (id_main),
        .reg_id    (reg_id),
        .accept_wr (accept_wr),
        .wdata     (wdata),
        .st        (st)
    );

    pmu_read_mux u_rmux (
        .reg_id (reg_id),
        .st     (st),
        .value  (rd_value)
    );

    assign undef = refused;
    assign rdata = accept_rd ? rd_value : '0;

    // R13: a refused access returns zero data
    a_r13_undef_zero: assert property (@(posedge clk) disable iff (rst)
        undef |-> (rdata == '0));

    // R12: a refused access leaves all state untouched
    a_r12_refused_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && undef) |=> $stable(st));

    // R11: gated registers closed to user level while user-enable is low
    a_r11_gated_closed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && !st.usr_en && pmu_class(reg_id) == AC_GATED) |-> undef);

endmodule

// File: tb/sim_pmu_sysreg_file.sv
module sim_pmu_sysreg_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] id_main = 32'h41AB_CDEF;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [3:0]  sel_primary = 4'd0;
    logic [3:0]  sel_secondary = 4'd0;
    logic [2:0]  sel_op1 = 3'd0;
    logic [2:0]  sel_op2 = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        undef;

    always #2 clk = ~clk;

    pmu_sysreg_file u0 (
        .clk(clk), .rst(rst), .id_main(id_main),
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .sel_primary(sel_primary), .sel_secondary(sel_secondary),
        .sel_op1(sel_op1), .sel_op2(sel_op2),
        .wdata(wdata), .rdata(rdata), .undef(undef)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model of stored state, derived from the requirements
    logic [31:0] m_ctrl;
    logic        m_cnt, m_int, m_usr;
    logic [31:0] m_ovf;
    logic [7:0]  m_evt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input logic [31:0] id);
        m_ctrl = {id[31:24], 24'd0};
        m_cnt = 1'b0; m_int = 1'b0; m_usr = 1'b0;
        m_ovf = 32'd0; m_evt = 8'd0;
    endtask

    task automatic predict(input logic wr, input logic pv, input logic [3:0] pr,
                           input logic [3:0] sc, input logic [2:0] o1, input logic [2:0] o2,
                           output logic eu, output logic [31:0] er, output string tag);
        logic mapped, ok;
        mapped = (pr == 4'd9) && (o1 == 3'd0) &&
                 ((sc == 4'd12 && o2 <= 3'd5) || (sc == 4'd13 && o2 <= 3'd2) ||
                  (sc == 4'd14 && o2 <= 3'd2));
        if (!mapped) begin
            ok = 1'b0; tag = "R12 sweep";
        end else if (sc == 4'd14 && o2 != 3'd0) begin
            ok = pv; tag = "R9 sweep";
        end else if (sc == 4'd14) begin
            ok = pv || !wr; tag = "R10 sweep";
        end else begin
            ok = pv || m_usr; tag = "R11 sweep";
        end
        eu = !ok;
        er = 32'd0;
        if (ok && !wr) begin
            if (sc == 4'd12 && o2 == 3'd0) er = m_ctrl;
            else if (sc == 4'd12 && (o2 == 3'd1 || o2 == 3'd2)) er = {m_cnt, 31'd0};
            else if (sc == 4'd12 && o2 == 3'd3) er = m_ovf;
            else if (sc == 4'd13 && o2 == 3'd1) er = {24'd0, m_evt};
            else if (sc == 4'd14 && o2 == 3'd0) er = {31'd0, m_usr};
            else if (sc == 4'd14) er = {m_int, 31'd0};
        end
    endtask

    task automatic commit(input logic wr, input logic ok, input logic [3:0] sc,
                          input logic [2:0] o2, input logic [31:0] wd);
        if (ok && wr) begin
            if (sc == 4'd12 && o2 == 3'd0) m_ctrl = (m_ctrl & ~32'h39) | (wd & 32'h39);
            else if (sc == 4'd12 && o2 == 3'd1) m_cnt = m_cnt | wd[31];
            else if (sc == 4'd12 && o2 == 3'd2) m_cnt = m_cnt & ~wd[31];
            else if (sc == 4'd12 && o2 == 3'd3) m_ovf = m_ovf & ~wd;
            else if (sc == 4'd13 && o2 == 3'd1) m_evt = wd[7:0];
            else if (sc == 4'd14 && o2 == 3'd0) m_usr = wd[0];
            else if (sc == 4'd14 && o2 == 3'd1) m_int = m_int | wd[31];
            else if (sc == 4'd14 && o2 == 3'd2) m_int = m_int & ~wd[31];
        end
    endtask

    // one access; returns sampled outputs, keeps the model in step
    task automatic xfer(input logic wr, input logic pv, input logic [3:0] pr,
                        input logic [3:0] sc, input logic [2:0] o1, input logic [2:0] o2,
                        input logic [31:0] wd, output logic gu, output logic [31:0] gr);
        logic eu; logic [31:0] er; string tag;
        predict(wr, pv, pr, sc, o1, o2, eu, er, tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_priv = pv;
        sel_primary = pr; sel_secondary = sc; sel_op1 = o1; sel_op2 = o2; wdata = wd;
        #1;
        gu = undef; gr = rdata;
        @(posedge clk);
        #1 req_valid = 1'b0;
        commit(wr, !eu, sc, o2, wd);
    endtask

    task automatic pwr(input logic pv, input logic [3:0] sc, input logic [2:0] o2,
                       input logic [31:0] wd, input logic exp_u, input string tag);
        logic gu; logic [31:0] gr;
        xfer(1'b1, pv, 4'd9, sc, 3'd0, o2, wd, gu, gr);
        chk({tag, " undef"}, {31'd0, gu}, {31'd0, exp_u});
        chk({tag, " wr-rdata"}, gr, 32'd0);
    endtask

    task automatic prd(input logic pv, input logic [3:0] sc, input logic [2:0] o2,
                       input logic [31:0] exp_r, input logic exp_u, input string tag);
        logic gu; logic [31:0] gr;
        xfer(1'b0, pv, 4'd9, sc, 3'd0, o2, 32'd0, gu, gr);
        chk({tag, " undef"}, {31'd0, gu}, {31'd0, exp_u});
        chk({tag, " rdata"}, gr, exp_r);
    endtask

    task automatic do_reset(input logic [31:0] id);
        @(negedge clk);
        rst = 1'b1; id_main = id;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        model_reset(id);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic gu, eu;
        logic [31:0] gr, er;
        string tag;
        int idx;

        do_reset(32'h41AB_CDEF);

        // R13: idle outputs
        #1;
        chk("R13 idle undef", {31'd0, undef}, 32'd0);
        chk("R13 idle rdata", rdata, 32'd0);

        // R1: reset values
        prd(1'b1, 4'd12, 3'd0, 32'h4100_0000, 1'b0, "R1 ctrl reset");
        prd(1'b1, 4'd12, 3'd1, 32'h0, 1'b0, "R1 cnten reset");
        prd(1'b1, 4'd14, 3'd1, 32'h0, 1'b0, "R1 inten reset");
        prd(1'b1, 4'd13, 3'd1, 32'h0, 1'b0, "R1 evtype reset");
        prd(1'b1, 4'd14, 3'd0, 32'h0, 1'b0, "R1 usren reset");

        // R2: masked control write
        pwr(1'b1, 4'd12, 3'd0, 32'hFFFF_FFFF, 1'b0, "R2 ctrl ones");
        prd(1'b1, 4'd12, 3'd0, 32'h4100_0039, 1'b0, "R2 ctrl ones");
        pwr(1'b1, 4'd12, 3'd0, 32'h0000_0006, 1'b0, "R2 ctrl low");
        prd(1'b1, 4'd12, 3'd0, 32'h4100_0000, 1'b0, "R2 ctrl low");

        // R3: count-enable pair
        pwr(1'b1, 4'd12, 3'd1, 32'h7FFF_FFFF, 1'b0, "R3 set low bits");
        prd(1'b1, 4'd12, 3'd1, 32'h0, 1'b0, "R3 set low bits");
        pwr(1'b1, 4'd12, 3'd1, 32'h8000_0000, 1'b0, "R3 set");
        prd(1'b1, 4'd12, 3'd2, 32'h8000_0000, 1'b0, "R3 set via clr view");
        pwr(1'b1, 4'd12, 3'd2, 32'h7FFF_FFFF, 1'b0, "R3 clr low bits");
        prd(1'b1, 4'd12, 3'd1, 32'h8000_0000, 1'b0, "R3 clr low bits");
        pwr(1'b1, 4'd12, 3'd2, 32'h8000_0000, 1'b0, "R3 clr");
        prd(1'b1, 4'd12, 3'd1, 32'h0, 1'b0, "R3 clr");

        // R4: interrupt-enable pair
        pwr(1'b1, 4'd14, 3'd1, 32'hFFFF_FFFF, 1'b0, "R4 set");
        prd(1'b1, 4'd14, 3'd2, 32'h8000_0000, 1'b0, "R4 set");
        prd(1'b1, 4'd12, 3'd1, 32'h0, 1'b0, "R4 independent of cnten");
        pwr(1'b1, 4'd14, 3'd2, 32'h8000_0000, 1'b0, "R4 clr");
        prd(1'b1, 4'd14, 3'd1, 32'h0, 1'b0, "R4 clr");

        // R5: overflow status
        pwr(1'b1, 4'd12, 3'd3, 32'hFFFF_FFFF, 1'b0, "R5 w1c");
        prd(1'b1, 4'd12, 3'd3, 32'h0, 1'b0, "R5 w1c");

        // R6 / R7
        pwr(1'b1, 4'd13, 3'd1, 32'h1234_56AB, 1'b0, "R6 evtype");
        prd(1'b1, 4'd13, 3'd1, 32'h0000_00AB, 1'b0, "R6 evtype");
        pwr(1'b1, 4'd14, 3'd0, 32'hFFFF_FFFE, 1'b0, "R7 usren zero");
        prd(1'b1, 4'd14, 3'd0, 32'h0, 1'b0, "R7 usren zero");
        pwr(1'b1, 4'd14, 3'd0, 32'h0000_0003, 1'b0, "R7 usren one");
        prd(1'b1, 4'd14, 3'd0, 32'h1, 1'b0, "R7 usren one");

        // R8: zero locations
        pwr(1'b1, 4'd12, 3'd4, 32'hFFFF_FFFF, 1'b0, "R8 swinc");
        prd(1'b1, 4'd12, 3'd4, 32'h0, 1'b0, "R8 swinc");
        pwr(1'b1, 4'd12, 3'd5, 32'hFFFF_FFFF, 1'b0, "R8 csel");
        prd(1'b1, 4'd12, 3'd5, 32'h0, 1'b0, "R8 csel");
        pwr(1'b1, 4'd13, 3'd0, 32'hFFFF_FFFF, 1'b0, "R8 cycle");
        prd(1'b1, 4'd13, 3'd0, 32'h0, 1'b0, "R8 cycle");
        pwr(1'b1, 4'd13, 3'd2, 32'hFFFF_FFFF, 1'b0, "R8 evcnt");
        prd(1'b1, 4'd13, 3'd2, 32'h0, 1'b0, "R8 evcnt");

        // R9..R11 with user-enable = 1
        prd(1'b0, 4'd12, 3'd0, 32'h4100_0000, 1'b0, "R11 user open read");
        pwr(1'b0, 4'd14, 3'd1, 32'h8000_0000, 1'b1, "R9 user inten set");
        prd(1'b1, 4'd14, 3'd1, 32'h0, 1'b0, "R9 inten unchanged");
        prd(1'b0, 4'd14, 3'd2, 32'h0, 1'b1, "R9 user inten read");
        prd(1'b0, 4'd14, 3'd0, 32'h1, 1'b0, "R10 user usren read");
        pwr(1'b0, 4'd14, 3'd0, 32'h0, 1'b1, "R10 user usren write");
        prd(1'b1, 4'd14, 3'd0, 32'h1, 1'b0, "R10 usren unchanged");

        // R11 with user-enable = 0
        pwr(1'b1, 4'd14, 3'd0, 32'h0, 1'b0, "R11 close");
        prd(1'b0, 4'd12, 3'd0, 32'h0, 1'b1, "R11 user closed read");
        pwr(1'b0, 4'd13, 3'd1, 32'h0000_0055, 1'b1, "R11 user closed write");
        prd(1'b1, 4'd13, 3'd1, 32'h0000_00AB, 1'b0, "R12 refused no change");

        // R12: unmapped selects
        xfer(1'b1, 1'b1, 4'd9, 4'd12, 3'd1, 3'd0, 32'h39, gu, gr);
        chk("R12 op1 nonzero undef", {31'd0, gu}, 32'd1);
        prd(1'b1, 4'd12, 3'd0, 32'h4100_0000, 1'b0, "R12 op1 no change");
        xfer(1'b0, 1'b1, 4'd8, 4'd12, 3'd0, 3'd0, 32'h0, gu, gr);
        chk("R12 primary undef", {31'd0, gu}, 32'd1);
        chk("R13 undef rdata zero", gr, 32'd0);
        prd(1'b1, 4'd12, 3'd6, 32'h0, 1'b1, "R12 opcode 6");
        prd(1'b1, 4'd13, 3'd3, 32'h0, 1'b1, "R12 opcode 3 sec13");
        prd(1'b1, 4'd11, 3'd0, 32'h0, 1'b1, "R12 sec11");

        // near-exhaustive sweep against the model
        idx = 0;
        for (int u = 0; u < 2; u++) begin
            xfer(1'b1, 1'b1, 4'd9, 4'd14, 3'd0, 3'd0, {31'd0, u[0]}, gu, gr);
            for (int pv = 0; pv < 2; pv++)
                for (int w = 0; w < 2; w++)
                    for (int sc = 11; sc < 16; sc++)
                        for (int o2 = 0; o2 < 8; o2++)
                            for (int o1 = 0; o1 < 2; o1++)
                                for (int pr = 8; pr < 10; pr++) begin
                                    logic [31:0] wd;
                                    idx++;
                                    wd = 32'hA5F0_0F5A ^ (idx * 32'h9E37_79B9);
                                    if (sc == 14 && o2 == 0) wd[0] = u[0];
                                    predict(w[0], pv[0], pr[3:0], sc[3:0], o1[2:0], o2[2:0], eu, er, tag);
                                    xfer(w[0], pv[0], pr[3:0], sc[3:0], o1[2:0], o2[2:0], wd, gu, gr);
                                    chk({tag, " undef"}, {31'd0, gu}, {31'd0, eu});
                                    chk({tag, " rdata"}, gr, er);
                                end
        end

        // R1: second reset with a different identity
        do_reset(32'h56FF_FFFF);
        prd(1'b1, 4'd12, 3'd0, 32'h5600_0000, 1'b0, "R1 ctrl second reset");
        prd(1'b1, 4'd14, 3'd0, 32'h0, 1'b0, "R1 usren second reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule